// File: doc/BRIEF.md
# Burst Block-Copy Engine

This engine carries out one block-copy command at a time: a byte count, a source byte address and a destination byte address. Two flags come with each command. One says whether the source is in memory space or in I/O space, and the other says the same for the destination. The engine checks the command before it moves any data. If the two addresses have different low two bits, it rejects the command with a one-cycle illegal-instruction interrupt. If the count is zero, it finishes at once. Otherwise it loops until the count is used up. On each pass it asks a request/grant bus for a read burst, captures the returned words into an internal 16-word FIFO, asks for a write burst of the same length, and drains the FIFO to the destination. Both addresses are used directly as given, with no indirection. The pointers and the remaining count are kept in working registers of their own.

Commands arrive on a valid/ready handshake. `cmd_ready` is high only while the engine is idle, so a new command waits (back-pressure) until the previous one has produced its completion or interrupt pulse. Read data comes back on a valid/ready stream, and the engine holds `rd_ready` high for the whole read data phase. Write data leaves on a valid/ready stream. The sink may hold `wr_ready` low for any number of cycles, and the engine then keeps `wr_data` and `wr_be` stable. A burst covers at most 64 bytes and never runs past the remaining count. Because source and destination share the same offset inside a word, the byte enables captured on the read side apply unchanged on the write side.

Top module: `blkcopy_engine`

## Requirements
- R1: `cmd_ready` is 1 in the idle state (including right after reset) and 0 from the cycle after a command is accepted until the cycle its `fetch_next` or `illegal_irq` pulse appears.
- R2: If `cmd_src[1:0]` differs from `cmd_dst[1:0]`, `illegal_irq` is 1 for exactly the one cycle after acceptance, no bus request is made and no byte in either space changes.
- R3: A legal command with `cmd_count` of 0 raises `fetch_next` for exactly the one cycle after acceptance, with no bus request.
- R4: A legal command with count N copies the bytes at src..src+N-1 to dst..dst+N-1, and no other byte changes. `wr_be` bit j enables byte lane j, which is the byte whose address has low bits equal to j. Data words are little-endian, with lane j in bits 8j+7:8j.
- R5: Each read burst covers min(remaining, 64 - src[1:0]) bytes. Its `bus_len` is the number of words that span touches (1 to 16). `bus_addr` is the word-aligned address, with bits [1:0] = 0. Each read burst is followed by one write burst of equal length to the destination, and the FIFO never overflows or underflows.
- R6: `bus_io` equals the source flag on read requests (`bus_we`=0) and the destination flag on write requests (`bus_we`=1); 1 means I/O space.
- R7: While `bus_req` is 1 and `bus_gnt` is 0, the request and its `bus_addr`, `bus_len`, `bus_we` and `bus_io` stay unchanged on the next cycle.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_data` and `wr_be` stay unchanged on the next cycle, and every beat offered has a nonzero `wr_be`.
- R9: `fetch_next` for a nonzero count is a one-cycle pulse in the cycle after the last write beat handshake, and the engine is idle again in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_src | input | 32 | Source byte address |
| cmd_dst | input | 32 | Destination byte address |
| cmd_count | input | 24 | Byte count, 0 to 16M-1 |
| cmd_src_io | input | 1 | 1: source in I/O space, 0: memory space |
| cmd_dst_io | input | 1 | 1: destination in I/O space, 0: memory space |
| fetch_next | output | 1 | One-cycle pulse: copy finished, next instruction may be fetched |
| illegal_irq | output | 1 | One-cycle pulse: address alignment mismatch |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant, one cycle |
| bus_we | output | 1 | 1: write burst, 0: read burst |
| bus_io | output | 1 | Space select for the request |
| bus_addr | output | 32 | Word-aligned burst start address |
| bus_len | output | 5 | Burst length in words |
| rd_valid | input | 1 | Read beat valid |
| rd_ready | output | 1 | Engine accepts read beats |
| rd_data | input | 32 | Read beat data |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Sink accepts write beat |
| wr_data | output | 32 | Write beat data |
| wr_be | output | 4 | Write byte lane enables |

## Verification
The bench drives commands and bus responses on the falling edge and samples there too, so each output is read half a cycle after the edge that produced it. The illegal-instruction and zero-count pulses are due one edge after acceptance. The bench reads them at the falling edge straight after the accepting edge, and again one cycle later to confirm they have dropped. For a nonzero copy, the bus model notes the edge number of the last write handshake. The completion pulse must appear at that same edge count. Memory contents, burst counts, beat totals and space flags are compared once the command has finished.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RREQ,
    ST_RDAT,
    ST_WREQ,
    ST_WDAT
  } blk_state_e;
endpackage

// File: rtl/blkcopy_fifo.sv
module blkcopy_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   fill;

  assign full  = (fill == (PW+1)'(DEPTH));
  assign empty = (fill == '0);
  assign dout  = store[rp];

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      fill <= fill + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/blkcopy_burst_plan.sv
module blkcopy_burst_plan #(
  parameter int CW        = 24,
  parameter int MAX_BURST = 16,
  localparam int CAPB     = MAX_BURST * 4,
  localparam int BW       = $clog2(CAPB + 1),
  localparam int LW       = $clog2(MAX_BURST + 1)
) (
  input  logic [1:0]    offset,
  input  logic [CW-1:0] remain,
  output logic [BW-1:0] bytes,
  output logic [LW-1:0] words
);
  logic [BW-1:0] cap;
  logic [BW:0]   span;

  always_comb begin
    cap   = BW'(CAPB) - BW'(offset);
    bytes = (remain < CW'(cap)) ? remain[BW-1:0] : cap;
    span  = (BW+1)'(bytes) + (BW+1)'(offset) + (BW+1)'(3);
    words = span[LW+1:2];
  end
endmodule

// File: rtl/blkcopy_lane_mask.sv
module blkcopy_lane_mask #(
  parameter int MAX_BURST = 16,
  localparam int IW       = $clog2(MAX_BURST),
  localparam int BW       = $clog2(MAX_BURST * 4 + 1)
) (
  input  logic [IW-1:0] word_idx,
  input  logic [1:0]    offset,
  input  logic [BW-1:0] bytes,
  output logic [3:0]    be
);
  logic [BW:0] lo, hi;
  assign lo = (BW+1)'(offset);
  assign hi = (BW+1)'(offset) + (BW+1)'(bytes);

  for (genvar j = 0; j < 4; j++) begin : g_lane
    logic [BW:0] pos;
    assign pos   = (BW+1)'({word_idx, 2'(j)});
    assign be[j] = (pos >= lo) && (pos < hi);
  end
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine #(
  parameter int AW         = 32,
  parameter int CW         = 24,
  parameter int MAX_BURST  = 16,
  parameter int FIFO_WORDS = 16,
  localparam int LW        = $clog2(MAX_BURST + 1),
  localparam int IW        = $clog2(MAX_BURST),
  localparam int BW        = $clog2(MAX_BURST * 4 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_src,
  input  logic [AW-1:0] cmd_dst,
  input  logic [CW-1:0] cmd_count,
  input  logic          cmd_src_io,
  input  logic          cmd_dst_io,
  output logic          fetch_next,
  output logic          illegal_irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_we,
  output logic          bus_io,
  output logic [AW-1:0] bus_addr,
  output logic [LW-1:0] bus_len,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [31:0]   rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [31:0]   wr_data,
  output logic [3:0]    wr_be
);
  import blkcopy_pkg::*;

  blk_state_e    st;
  logic [AW-1:0] src_p, dst_p;
  logic [CW-1:0] rem;
  logic          s_io, d_io;
  logic [IW-1:0] beat;
  logic          done_q, ill_q;

  logic [BW-1:0] b_bytes;
  logic [LW-1:0] b_words;
  logic [3:0]    cap_be;
  logic          last_beat;
  logic          f_push, f_pop, f_full, f_empty;
  logic [35:0]   f_out;

  blkcopy_burst_plan #(.CW(CW), .MAX_BURST(MAX_BURST)) u_plan (
    .offset(src_p[1:0]), .remain(rem), .bytes(b_bytes), .words(b_words)
  );

  blkcopy_lane_mask #(.MAX_BURST(MAX_BURST)) u_mask (
    .word_idx(beat), .offset(src_p[1:0]), .bytes(b_bytes), .be(cap_be)
  );

  blkcopy_fifo #(.W(36), .DEPTH(FIFO_WORDS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(f_push), .din({cap_be, rd_data}),
    .pop(f_pop), .dout(f_out), .full(f_full), .empty(f_empty)
  );

  assign last_beat   = (LW'(beat) == b_words - 1'b1);
  assign cmd_ready   = (st == ST_IDLE);
  assign fetch_next  = done_q;
  assign illegal_irq = ill_q;
  assign bus_req     = (st == ST_RREQ) || (st == ST_WREQ);
  assign bus_we      = (st == ST_WREQ);
  assign bus_io      = (st == ST_WREQ) ? d_io : s_io;
  assign bus_addr    = (st == ST_WREQ) ? {dst_p[AW-1:2], 2'b00} : {src_p[AW-1:2], 2'b00};
  assign bus_len     = b_words;
  assign rd_ready    = (st == ST_RDAT);
  assign f_push      = rd_ready && rd_valid;
  assign wr_valid    = (st == ST_WDAT) && !f_empty;
  assign f_pop       = wr_valid && wr_ready;
  assign wr_data     = f_out[31:0];
  assign wr_be       = f_out[35:32];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      src_p <= '0;
      dst_p <= '0;
      rem <= '0;
      s_io <= 1'b0;
      d_io <= 1'b0;
      beat <= '0;
      done_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          if (cmd_src[1:0] != cmd_dst[1:0]) ill_q <= 1'b1;
          else if (cmd_count == '0) done_q <= 1'b1;
          else begin
            src_p <= cmd_src;
            dst_p <= cmd_dst;
            rem   <= cmd_count;
            s_io  <= cmd_src_io;
            d_io  <= cmd_dst_io;
            st    <= ST_RREQ;
          end
        end
        ST_RREQ: if (bus_gnt) begin
          beat <= '0;
          st   <= ST_RDAT;
        end
        ST_RDAT: if (rd_valid) begin
          if (last_beat) begin
            beat <= '0;
            st   <= ST_WREQ;
          end else beat <= beat + 1'b1;
        end
        ST_WREQ: if (bus_gnt) begin
          beat <= '0;
          st   <= ST_WDAT;
        end
        ST_WDAT: if (f_pop) begin
          if (last_beat) begin
            beat  <= '0;
            src_p <= src_p + AW'(b_bytes);
            dst_p <= dst_p + AW'(b_bytes);
            rem   <= rem - CW'(b_bytes);
            if (rem == CW'(b_bytes)) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end else st <= ST_RREQ;
          end else beat <= beat + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: an interrupt only follows an accepted misaligned command
  a_r2_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_irq |-> $past(cmd_valid && cmd_ready && (cmd_src[1:0] != cmd_dst[1:0])));
  a_r2_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_irq |=> !illegal_irq);
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_next |=> !fetch_next);
  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_len != '0) && (bus_len <= LW'(MAX_BURST)) && (bus_addr[1:0] == 2'b00));
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req && $stable(bus_addr) && $stable(bus_len)
                              && $stable(bus_we) && $stable(bus_io));
  a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_data) && $stable(wr_be));
  a_r8_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_be != 4'b0000));
endmodule

// File: tb/tb_blkcopy_engine.sv
module tb_blkcopy_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {src[15:0], dst[15:0], count[23:0], src_io, dst_io}
  localparam logic [57:0] VEC [NVEC] = '{
    {16'h0000, 16'h0100, 24'd4,   1'b0, 1'b0},
    {16'h0003, 16'h0107, 24'd1,   1'b0, 1'b0},
    {16'h0001, 16'h00C5, 24'd70,  1'b0, 1'b0},
    {16'h0002, 16'h017A, 24'd130, 1'b1, 1'b0},
    {16'h0010, 16'h0110, 24'd0,   1'b0, 1'b0},
    {16'h0001, 16'h0102, 24'd8,   1'b0, 1'b0},
    {16'h0040, 16'h0140, 24'd64,  1'b0, 1'b1},
    {16'h0006, 16'h0016, 24'd3,   1'b1, 1'b1},
    {16'h0000, 16'h0100, 24'd200, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_src = '0, cmd_dst = '0;
  logic [23:0] cmd_count = '0;
  logic cmd_src_io = 1'b0, cmd_dst_io = 1'b0;
  logic fetch_next, illegal_irq;
  logic bus_req, bus_gnt = 1'b0, bus_we, bus_io;
  logic [31:0] bus_addr;
  logic [4:0] bus_len;
  logic rd_valid = 1'b0, rd_ready;
  logic [31:0] rd_data = '0;
  logic wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_data;
  logic [3:0] wr_be;

  blkcopy_engine dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [7:0] mem_m [512], mem_i [512], exp_m [512], exp_i [512];
  int ph = 0, dly = 0, beat = 0, tick = 0;
  logic [31:0] l_addr; int l_len; logic l_we, l_io;
  logic pend = 1'b0; logic [31:0] h_addr; logic [4:0] h_len; logic h_we, h_io;
  logic wpend = 1'b0; logic [31:0] h_wd; logic [3:0] h_be;
  logic e_sio, e_dio;
  int n_rbursts, n_wbursts, n_rbeats, n_wbeats, io_err, hold_viol, len_err;
  int last_hs, done_seen, done_cyc, ill_seen;

  task automatic check(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fetch_next) begin done_seen++; done_cyc = cyc; end
      if (illegal_irq) ill_seen++;
    end
  end

  // bus responder: request/grant, read source, write sink with stalls
  always @(negedge clk) begin
    if (!rst_n) begin
      ph = 0; dly = 0; pend = 1'b0; wpend = 1'b0;
      bus_gnt = 1'b0; rd_valid = 1'b0; wr_ready = 1'b0;
    end else begin
      tick++;
      if (ph == 0) begin
        rd_valid = 1'b0; wr_ready = 1'b0;
        if (bus_req) begin
          if (pend && (bus_addr != h_addr || bus_len != h_len || bus_we != h_we || bus_io != h_io))
            hold_viol++;
          pend = 1'b1; h_addr = bus_addr; h_len = bus_len; h_we = bus_we; h_io = bus_io;
          if (dly == 1) begin
            bus_gnt = 1'b1; dly = 0; pend = 1'b0;
            l_addr = bus_addr; l_len = int'(bus_len); l_we = bus_we; l_io = bus_io;
            if (bus_len == 0 || bus_len > 16 || bus_addr[1:0] != 2'b00) len_err++;
            if (bus_we) begin n_wbursts++; if (bus_io != e_dio) io_err++; end
            else begin n_rbursts++; if (bus_io != e_sio) io_err++; end
            ph = 1;
          end else dly++;
        end
      end else if (ph == 1) begin
        bus_gnt = 1'b0; beat = 0; wpend = 1'b0;
        ph = l_we ? 3 : 2;
      end
      if (ph == 2) begin
        if (tick % 4 == 3) rd_valid = 1'b0;
        else begin
          int a;
          a = int'(l_addr) + 4*beat;
          rd_valid = 1'b1;
          for (int j = 0; j < 4; j++)
            rd_data[8*j +: 8] = l_io ? mem_i[(a+j) & 511] : mem_m[(a+j) & 511];
          if (rd_ready) begin beat++; n_rbeats++; end
          if (beat == l_len) ph = 0;
        end
      end else if (ph == 3) begin
        if (wpend && (!wr_valid || wr_data != h_wd || wr_be != h_be)) hold_viol++;
        wr_ready = (tick % 4 != 1);
        wpend = wr_valid && !wr_ready; h_wd = wr_data; h_be = wr_be;
        if (wr_valid && wr_ready) begin
          int a;
          a = int'(l_addr) + 4*beat;
          for (int j = 0; j < 4; j++)
            if (wr_be[j]) begin
              if (l_io) mem_i[(a+j) & 511] = wr_data[8*j +: 8];
              else      mem_m[(a+j) & 511] = wr_data[8*j +: 8];
            end
          beat++; n_wbeats++; last_hs = cyc + 1;
          if (beat == l_len) ph = 0;
        end
      end
    end
  end

  task automatic prep(input int v, input logic [31:0] s, input logic [31:0] d,
                      input int cnt, input logic sio, input logic dio);
    for (int i = 0; i < 512; i++) begin
      mem_m[i] = 8'(i*7 + v*3 + 1);
      mem_i[i] = 8'(i*13 + v + 85);
      exp_m[i] = mem_m[i];
      exp_i[i] = mem_i[i];
    end
    if (s[1:0] == d[1:0])
      for (int b = 0; b < cnt; b++) begin
        logic [7:0] x;
        x = sio ? mem_i[(s+b) & 511] : mem_m[(s+b) & 511];
        if (dio) exp_i[(d+b) & 511] = x; else exp_m[(d+b) & 511] = x;
      end
    e_sio = sio; e_dio = dio;
    n_rbursts = 0; n_wbursts = 0; n_rbeats = 0; n_wbeats = 0;
    io_err = 0; hold_viol = 0; len_err = 0; last_hs = -1;
    done_seen = 0; done_cyc = -2; ill_seen = 0;
  endtask

  task automatic issue(input logic [31:0] s, input logic [31:0] d, input int cnt,
                       input logic sio, input logic dio);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_src = s; cmd_dst = d; cmd_count = 24'(cnt);
    cmd_src_io = sio; cmd_dst_io = dio;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_vec(input int v, input logic [31:0] s, input logic [31:0] d,
                         input int cnt, input logic sio, input logic dio);
    bit bad;
    int r, o, eb, ebeats, mism, w;
    bad = (s[1:0] != d[1:0]);
    prep(v, s, d, cnt, sio, dio);
    issue(s, d, cnt, sio, dio);
    if (bad) begin
      check("R2 illegal_irq after accept", illegal_irq, 1);
      check("R1 ready after irq", cmd_ready, 1);
      @(negedge clk);
      check("R2 irq one cycle", illegal_irq, 0);
    end else if (cnt == 0) begin
      check("R3 fetch_next after accept", fetch_next, 1);
      @(negedge clk);
      check("R3 fetch_next one cycle", fetch_next, 0);
    end else begin
      check("R1 busy not ready", cmd_ready, 0);
      w = 0;
      while (done_seen == 0 && w < 20000) begin @(negedge clk); w++; end
      check("R9 done timing", done_cyc, last_hs);
      check("R1 ready at done", cmd_ready, 1);
      @(negedge clk);
      check("R9 done one cycle", fetch_next, 0);
    end
    repeat (4) @(negedge clk);
    r = bad ? 0 : cnt; o = int'(s[1:0]); eb = 0; ebeats = 0;
    while (r > 0) begin
      int b;
      b = (r < 64 - o) ? r : 64 - o;
      ebeats += (o + b + 3) / 4;
      eb++; r -= b; o = 0;
    end
    mism = 0;
    for (int i = 0; i < 512; i++)
      if (mem_m[i] != exp_m[i] || mem_i[i] != exp_i[i]) mism++;
    check(bad ? "R2 no data moved" : "R4 copy contents", mism, 0);
    check(cnt == 0 || bad ? "R3 R2 no read bursts" : "R5 read bursts", n_rbursts, eb);
    check("R5 write bursts", n_wbursts, eb);
    check("R5 read beats", n_rbeats, ebeats);
    check("R5 write beats", n_wbeats, ebeats);
    check("R5 len and address", len_err, 0);
    check("R6 space select", io_err, 0);
    check("R7 R8 hold while stalled", hold_viol, 0);
    check("R2 irq count", ill_seen, bad ? 1 : 0);
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    check("R1 reset cmd_ready", cmd_ready, 1);
    check("R1 reset bus_req", bus_req, 0);
    check("R9 reset fetch_next", fetch_next, 0);
    check("R2 reset illegal_irq", illegal_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NVEC; v++) begin
      logic [57:0] e;
      e = VEC[v];
      run_vec(v, 32'(e[57:42]), 32'(e[41:26]), int'(e[25:2]), e[1], e[0]);
    end
    // reset in the middle of a long move
    prep(20, 32'h0, 32'h100, 200, 1'b0, 1'b0);
    issue(32'h0, 32'h100, 200, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    check("R1 busy mid move", cmd_ready, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid move ready", cmd_ready, 1);
    check("R7 reset mid move req", bus_req, 0);
    check("R8 reset mid move wr_valid", wr_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(21, 32'h1, 32'h1F5, 9, 1'b1, 1'b0);
    w = 0;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule